// File: doc/BRIEF.md
# Port-Based VLAN Egress Filter

This block sits in the forwarding path of a small multi-port switch. For each frame it is handed the ingress port and the set of ports that address lookup would like to send the frame to. It returns the subset of those ports the frame is actually allowed to reach. It also returns the default VLAN identifier and the default priority assigned to the ingress port, so that untagged traffic can be classified.

Membership is not held in a tag-indexed VLAN table. Each port instead owns a bitmap of the egress ports it may reach. A two-bit state per port gates both ingress and egress: only a port in the forwarding state may source or receive traffic.

A host programs three registers per port through a simple register interface, plus one global register that selects the CPU-facing port. The host sees the written data on the next clock. The filter result is combinational from the port inputs and the stored registers.

Top module: `pvlan_filter`

## Requirements
- R1: After reset, every port state reads 0 (disabled), every egress map reads 0, every default VID reads 1 with priority 0, and the CPU port selection reads 5.
- R2: Selector 0 is the port control register. Bits 1:0 hold the port state: 0 disabled, 1 listening, 2 learning, 3 forwarding. All other bits read 0.
- R3: Selector 2 is the default-tag register. Bits 11:0 hold the default VID and bits 15:14 hold the default priority. Bits 13:12 read 0.
- R4: Selector 1 is the egress map. Bit i permits port i, for i below the port count (6). A port's own bit is always cleared when it is written, and bits above the port count read 0.
- R5: When the source port is forwarding, the egress mask equals the requested mask AND the source's map AND the set of forwarding ports, with the source's own bit cleared, and drop is 0.
- R6: When the source port is in state 0, 1 or 2, or its index is 6 or more, the egress mask is all zeros and drop is 1.
- R7: A destination port in state 0, 1 or 2 never appears in the egress mask, even if it is requested and mapped.
- R8: The default VID and default priority outputs show the source port's default-tag fields, whether or not the frame is dropped. For a source index of 6 or more they are 0.
- R9: Selector 3 holds the CPU port in bits 2:0. Writing 4 or 5 stores that value, and writing any other value stores 5. The stored value also drives the CPU port output.
- R10: A host write to a port index of 6 or more changes no register, and a read of such an index (selectors 0 to 2) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_port | input | 3 | Port index addressed by the host |
| host_sel | input | 2 | Register selector: 0 control, 1 map, 2 default tag, 3 CPU port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the addressed register |
| src_port | input | 3 | Ingress port of the frame |
| req_mask | input | 6 | Requested destination ports |
| egress_mask | output | 6 | Permitted destination ports |
| drop | output | 1 | Frame refused because the source is not forwarding |
| dflt_vid | output | 12 | Default VID of the source port |
| dflt_pri | output | 2 | Default priority of the source port |
| cpu_port | output | 3 | Selected CPU-facing port (4 or 5) |

## Verification
The bench targets a destination that is requested and mapped but sits in the listening or learning state. A design that only tests the disabled code would let such frames leak. It writes a map containing the port's own bit and checks both the readback and the egress mask, which a design that forgot to mask the self bit would reflect back to the ingress port. It drives source indices 6 and 7, where a missing range check would index past the register array. It also writes illegal CPU selections such as 0 and 7, which a design lacking the fallback would store unchanged.

// File: rtl/pvf_pkg.sv
package pvf_pkg;

    localparam int REG_W     = 16;
    localparam int VID_W     = 12;
    localparam int PRI_W     = 2;
    localparam int PRI_LSB   = 14;
    localparam int CPU_W     = 3;
    localparam int CPU_ALT   = 4;
    localparam int CPU_DFLT  = 5;
    localparam int VID_RESET = 1;

    typedef enum logic [1:0] {
        PS_DISABLED = 2'd0,
        PS_LISTEN   = 2'd1,
        PS_LEARN    = 2'd2,
        PS_FORWARD  = 2'd3
    } port_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MAP  = 2'd1,
        SEL_TAG  = 2'd2,
        SEL_CPU  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PRI_W-1:0] pri;
        logic [VID_W-1:0] vid;
        port_state_e      state;
    } port_cfg_t;

    function automatic logic [REG_W-1:0] pack_tag(input port_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[VID_W-1:0] = c.vid;
        w[PRI_LSB +: PRI_W] = c.pri;
        return w;
    endfunction

    function automatic logic [CPU_W-1:0] legal_cpu(input logic [CPU_W-1:0] v);
        if (v == CPU_W'(CPU_ALT) || v == CPU_W'(CPU_DFLT))
            return v;
        return CPU_W'(CPU_DFLT);
    endfunction

endpackage

// File: rtl/pvf_port_regs.sv
module pvf_port_regs
    import pvf_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int PW     = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [PW-1:0]                   wr_port,
    input  logic [1:0]                      wr_sel,
    input  logic [REG_W-1:0]                wr_data,
    output port_cfg_t [NPORTS-1:0]          cfg_o,
    output logic [NPORTS-1:0][NPORTS-1:0]   map_o
);

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        localparam logic [NPORTS-1:0] OWN = NPORTS'(1) << g;
        logic hit;
        assign hit = wr_en && (wr_port == PW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[g].state <= PS_DISABLED;
                cfg_o[g].vid   <= VID_W'(VID_RESET);
                cfg_o[g].pri   <= '0;
                map_o[g]       <= '0;
            end else if (hit) begin
                case (reg_sel_e'(wr_sel))
                    SEL_CTRL: cfg_o[g].state <= port_state_e'(wr_data[1:0]);
                    SEL_MAP:  map_o[g] <= wr_data[NPORTS-1:0] & ~OWN;
                    SEL_TAG: begin
                        cfg_o[g].vid <= wr_data[VID_W-1:0];
                        cfg_o[g].pri <= wr_data[PRI_LSB +: PRI_W];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pvf_cpu_sel.sv
module pvf_cpu_sel
    import pvf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CPU_W-1:0]  wr_val,
    output logic [CPU_W-1:0]  cpu_o
);

    always_ff @(posedge clk) begin
        if (rst)
            cpu_o <= CPU_W'(CPU_DFLT);
        else if (wr_en)
            cpu_o <= legal_cpu(wr_val);
    end

endmodule

// File: rtl/pvf_egress_calc.sv
module pvf_egress_calc
    import pvf_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int PW     = 3
) (
    input  port_cfg_t [NPORTS-1:0]          cfg_i,
    input  logic [NPORTS-1:0][NPORTS-1:0]   map_i,
    input  logic [PW-1:0]                   src,
    input  logic [NPORTS-1:0]               req,
    output logic [NPORTS-1:0]               mask,
    output logic                            drop,
    output logic [VID_W-1:0]                vid,
    output logic [PRI_W-1:0]                pri
);

    logic [NPORTS-1:0] fwd_set;
    logic              src_ok;
    port_cfg_t         src_cfg;
    logic [NPORTS-1:0] src_map;

    for (genvar g = 0; g < NPORTS; g++) begin : g_fwd
        assign fwd_set[g] = (cfg_i[g].state == PS_FORWARD);
    end

    always_comb begin
        src_cfg = '0;
        src_map = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (src == PW'(i)) begin
                src_cfg = cfg_i[i];
                src_map = map_i[i];
            end
        end
        src_ok = (src_cfg.state == PS_FORWARD);
        drop   = !src_ok;
        mask   = src_ok ? (req & src_map & fwd_set & ~(NPORTS'(1) << src)) : '0;
        vid    = src_cfg.vid;
        pri    = src_cfg.pri;
    end

endmodule

// File: rtl/pvlan_filter.sv
module pvlan_filter
    import pvf_pkg::*;
#(
    parameter int NPORTS = 6,
    localparam int PW    = $clog2(NPORTS + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [PW-1:0]      host_port,
    input  logic [1:0]         host_sel,
    input  logic [REG_W-1:0]   host_wdata,
    output logic [REG_W-1:0]   host_rdata,
    input  logic [PW-1:0]      src_port,
    input  logic [NPORTS-1:0]  req_mask,
    output logic [NPORTS-1:0]  egress_mask,
    output logic               drop,
    output logic [VID_W-1:0]   dflt_vid,
    output logic [PRI_W-1:0]   dflt_pri,
    output logic [CPU_W-1:0]   cpu_port
);

    port_cfg_t [NPORTS-1:0]         cfg;
    logic [NPORTS-1:0][NPORTS-1:0]  map;
    logic                           cpu_wr;

    assign cpu_wr = host_wr && (reg_sel_e'(host_sel) == SEL_CPU);

    pvf_port_regs #(.NPORTS(NPORTS), .PW(PW)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr),
        .wr_port (host_port),
        .wr_sel  (host_sel),
        .wr_data (host_wdata),
        .cfg_o   (cfg),
        .map_o   (map)
    );

    pvf_cpu_sel cpu_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cpu_wr),
        .wr_val (host_wdata[CPU_W-1:0]),
        .cpu_o  (cpu_port)
    );

    pvf_egress_calc #(.NPORTS(NPORTS), .PW(PW)) calc_i (
        .cfg_i (cfg),
        .map_i (map),
        .src   (src_port),
        .req   (req_mask),
        .mask  (egress_mask),
        .drop  (drop),
        .vid   (dflt_vid),
        .pri   (dflt_pri)
    );

    always_comb begin
        host_rdata = '0;
        if (reg_sel_e'(host_sel) == SEL_CPU) begin
            host_rdata[CPU_W-1:0] = cpu_port;
        end else begin
            for (int i = 0; i < NPORTS; i++) begin
                if (host_port == PW'(i)) begin
                    case (reg_sel_e'(host_sel))
                        SEL_CTRL: host_rdata[1:0] = cfg[i].state;
                        SEL_MAP:  host_rdata[NPORTS-1:0] = map[i];
                        default:  host_rdata = pack_tag(cfg[i]);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pvf_checker.sv
module pvf_checker #(
    parameter int NPORTS = 6,
    parameter int PW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [PW-1:0]     src_port,
    input logic [NPORTS-1:0] req_mask,
    input logic [NPORTS-1:0] egress_mask,
    input logic              drop,
    input logic [2:0]        cpu_port
);

    // R5: never grant a port that was not requested
    a_r5_within_request: assert property (@(posedge clk) disable iff (rst)
        (egress_mask & ~req_mask) == '0);

    // R5: never reflect to the ingress port
    a_r5_no_reflect: assert property (@(posedge clk) disable iff (rst)
        !drop |-> (egress_mask & (NPORTS'(1) << src_port)) == '0);

    // R6: a dropped frame reaches nobody
    a_r6_drop_empty: assert property (@(posedge clk) disable iff (rst)
        drop |-> egress_mask == '0);

    // R6: an out-of-range source is always dropped
    a_r6_bad_src: assert property (@(posedge clk) disable iff (rst)
        (int'(src_port) >= NPORTS) |-> drop);

    // R9: only the two legal CPU ports can be selected
    a_r9_cpu_legal: assert property (@(posedge clk) disable iff (rst)
        cpu_port == 3'd4 || cpu_port == 3'd5);

    // R1: reset leaves the CPU selection at 5
    a_r1_cpu_reset: assert property (@(posedge clk)
        rst |=> cpu_port == 3'd5);

endmodule

bind pvlan_filter pvf_checker #(.NPORTS(NPORTS), .PW(PW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .src_port    (src_port),
    .req_mask    (req_mask),
    .egress_mask (egress_mask),
    .drop        (drop),
    .cpu_port    (cpu_port)
);

// File: tb/pvlan_filter_tb_top.sv
module pvlan_filter_tb_top;

    localparam int N = 6;

    logic        clk = 0;
    logic        rst = 1;
    logic        host_wr = 0;
    logic [2:0]  host_port = 0;
    logic [1:0]  host_sel = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic [2:0]  src_port = 0;
    logic [5:0]  req_mask = 0;
    logic [5:0]  egress_mask;
    logic        drop;
    logic [11:0] dflt_vid;
    logic [1:0]  dflt_pri;
    logic [2:0]  cpu_port;

    int errors = 0;
    int checks = 0;

    int m_state [N];
    int m_map   [N];
    int m_vid   [N];
    int m_pri   [N];
    int m_cpu;

    always #2 clk = ~clk;

    pvlan_filter dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_port(host_port),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .src_port(src_port), .req_mask(req_mask), .egress_mask(egress_mask),
        .drop(drop), .dflt_vid(dflt_vid), .dflt_pri(dflt_pri), .cpu_port(cpu_port)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input int p, input int s, input int d);
        if (s == 3) begin
            m_cpu = ((d & 7) == 4 || (d & 7) == 5) ? (d & 7) : 5;
        end else if (p < N) begin
            if (s == 0) m_state[p] = d & 3;
            if (s == 1) m_map[p] = d & 'h3f & ~(1 << p);
            if (s == 2) begin
                m_vid[p] = d & 'hfff;
                m_pri[p] = (d >> 14) & 3;
            end
        end
    endtask

    task automatic wr(input int p, input int s, input int d);
        @(negedge clk);
        host_wr = 1; host_port = 3'(p); host_sel = 2'(s); host_wdata = 16'(d);
        @(negedge clk);
        host_wr = 0;
        model_write(p, s, d);
    endtask

    function automatic int exp_read(input int p, input int s);
        if (s == 3) return m_cpu;
        if (p >= N) return 0;
        if (s == 0) return m_state[p];
        if (s == 1) return m_map[p];
        return m_vid[p] | (m_pri[p] << 14);
    endfunction

    task automatic rd_check(input string req, input int p, input int s);
        host_port = 3'(p); host_sel = 2'(s);
        #1;
        check(req, int'(host_rdata), exp_read(p, s));
    endtask

    function automatic int exp_mask(input int s, input int r);
        int fw = 0;
        if (s >= N) return 0;
        if (m_state[s] != 3) return 0;
        for (int i = 0; i < N; i++) if (m_state[i] == 3) fw |= (1 << i);
        return r & m_map[s] & fw & ~(1 << s) & 'h3f;
    endfunction

    task automatic look(input string req, input int s, input int r);
        src_port = 3'(s); req_mask = 6'(r);
        #1;
        check(req, int'(egress_mask), exp_mask(s, r));
        check("R6", int'(drop), (s >= N || m_state[s] != 3) ? 1 : 0);
        check("R8", int'(dflt_vid), s < N ? m_vid[s] : 0);
        check("R8", int'(dflt_pri), s < N ? m_pri[s] : 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < N; i++) begin
            m_state[i] = 0; m_map[i] = 0; m_vid[i] = 1; m_pri[i] = 0;
        end
        m_cpu = 5;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int p = 0; p < N; p++)
            for (int s = 0; s < 3; s++) rd_check("R1", p, s);
        rd_check("R1", 0, 3);
        check("R1", int'(cpu_port), 5);
        // R2 / R3 / R4 field layout
        wr(1, 0, 'hfffe); rd_check("R2", 1, 0);
        wr(2, 2, 'hffff); rd_check("R3", 2, 2);
        wr(2, 1, 'hffff); rd_check("R4", 2, 1);
        check("R4", int'(host_rdata), 'h3b);
        // R9 CPU selection fallback
        wr(0, 3, 4); rd_check("R9", 0, 3); check("R9", int'(cpu_port), 4);
        wr(0, 3, 7); rd_check("R9", 0, 3); check("R9", int'(cpu_port), 5);
        wr(0, 3, 4); wr(0, 3, 0); rd_check("R9", 0, 3);
        // R10 out-of-range index
        wr(6, 0, 3); wr(7, 1, 'h3f);
        rd_check("R10", 6, 0); rd_check("R10", 7, 1);
        for (int p = 0; p < N; p++) rd_check("R10", p, 0);
        // R5 / R7 directed: all forwarding, full maps
        for (int p = 0; p < N; p++) begin wr(p, 0, 3); wr(p, 1, 'h3f); end
        look("R5", 0, 'h3f);
        check("R5", int'(egress_mask), 'h3e);
        wr(3, 0, 1); wr(4, 0, 2);
        look("R7", 0, 'h3f);
        check("R7", int'(egress_mask), 'h26);
        wr(2, 0, 1); look("R6", 2, 'h3f);
        look("R6", 6, 'h3f); look("R6", 7, 'h3f);
        // random mix
        for (int it = 0; it < 3000; it++) begin
            int p, s, d;
            p = $urandom_range(0, 7);
            s = $urandom_range(0, 3);
            d = $urandom_range(0, 'hffff);
            if (s == 0 && $urandom_range(0, 1) == 1) d = d | 3;
            wr(p, s, d);
            rd_check(s == 1 ? "R4" : (s == 2 ? "R3" : (s == 3 ? "R9" : "R2")), p, s);
            look("R5", $urandom_range(0, 7), $urandom_range(0, 63));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule